// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by reading one page-table entry from physical memory. A requester hands over a virtual address and an access kind (read or write) with a ready/valid handshake. The block combines the page-table base with the virtual page number to form the entry's memory address, and it issues exactly one read on a request/response memory port whose latency may vary. It then checks the returned entry and reports either a translated physical address or one of two faults.

The virtual address is split into a page number (upper bits) and an in-page displacement (lower bits, 10 bits for 1 KB pages). The physical address is formed by joining the entry's frame number above the unchanged displacement. An entry whose valid flag is clear gives a missing-page fault. An access that the entry's rights flags do not allow gives a protection fault. Only one request is in flight at a time. The result stays on the outputs, marked by a one-cycle done pulse, until a new request is taken.

Top module: `page_xlate`

## Requirements
- R1: After reset, and after any reset asserted mid-transaction, `req_ready` is 1 and `mem_rd_valid`, `res_done`, `res_paddr`, `res_miss` and `res_prot` are all 0.
- R2: The entry address on `mem_rd_addr` is `ptbr + vaddr[31:10]` (a word address). Both operands are sampled in the cycle the request is accepted, so later changes to `ptbr` or `req_vaddr` have no effect on it.
- R3: One cycle after acceptance, `mem_rd_valid` rises and stays high with a steady address until `mem_rd_ready` is seen. It then falls and is not raised again for that request. `req_ready` is 0 from acceptance until the result cycle has passed.
- R4: Entry layout: bit 0 is the valid flag, bit 1 is read permission, bit 2 is write permission, and bits 31:10 are the frame number.
- R5: For a valid entry that permits the access, `res_paddr = {pte[31:10], vaddr[9:0]}`, with both fault flags 0.
- R6: An entry with bit 0 clear raises `res_miss` and not `res_prot`, whatever its rights flags, and gives `res_paddr` 0.
- R7: For a valid entry, a write without bit 2 or a read without bit 1 raises `res_prot` and not `res_miss`, and gives `res_paddr` 0.
- R8: `res_done` is high for exactly the one cycle after the response is taken. The result outputs then hold their values until the next response is taken.
- R9: `mem_rsp_valid` is ignored outside the wait-for-response phase. It changes no output and ends no transaction.
- R10: Any number of stall cycles before `mem_rd_ready` and before `mem_rsp_valid` is tolerated without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ptbr | input | 32 | Page-table base (word address) |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory took the read request |
| mem_rd_addr | output | 32 | Entry word address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry returned by memory |
| res_done | output | 1 | One-cycle result strobe |
| res_paddr | output | 32 | Translated physical address |
| res_miss | output | 1 | Missing-page fault |
| res_prot | output | 1 | Access-rights fault |

## Verification
The translation is tried with read and write requests against entries that cover every combination that matters. These are a fully permitted entry, an invalid entry with and without rights set (which shows that the missing fault wins), a read-only page written, a write-only page read, and a write-only page written. Page numbers and offsets at all-zero and all-ones show whether the frame is joined above the offset rather than added to it. Base values near the top of the space show that the entry address is a sum. Stall lengths before the read handshake and before the response vary from zero to several cycles. Each request also changes the base and the address inputs just after acceptance, which tells a design that samples them apart from one that keeps reading them live. Stray response strobes in idle and in the fetch phase, plus a reset in the middle of a transaction, cover the remaining control paths.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } xl_state_t;

  // entry flag positions
  localparam int unsigned FLAG_VALID = 0;
  localparam int unsigned FLAG_RD    = 1;
  localparam int unsigned FLAG_WR    = 2;
endpackage

// File: rtl/pxl_ctrl.sv
module pxl_ctrl
  import page_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic mem_rd_ready,
  input  logic rsp_valid,
  output logic req_ready,
  output logic accept,
  output logic rd_valid,
  output logic capture,
  output logic done
);
  xl_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (req_valid)    state_q <= ST_FETCH;
        ST_FETCH: if (mem_rd_ready) state_q <= ST_WAIT;
        ST_WAIT:  if (rsp_valid)    state_q <= ST_DONE;
        ST_DONE:                    state_q <= ST_IDLE;
        default:                    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_ready && req_valid;
    rd_valid  = (state_q == ST_FETCH);
    capture   = (state_q == ST_WAIT) && rsp_valid;
    done      = (state_q == ST_DONE);
  end

  // R3
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !mem_rd_ready |=> rd_valid);
  // R3
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !req_ready);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pxl_check.sv
module pxl_check
  import page_xlate_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned OFF_W      = 10,
  parameter int unsigned PTE_W      = 32,
  parameter bit          READ_CHECK = 1'b1
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             is_write,
  output logic [PA_W-1:0]  paddr,
  output logic             miss,
  output logic             prot
);
  localparam int unsigned PFN_W = PA_W - OFF_W;

  logic [PFN_W-1:0] frame;
  logic             ent_valid;
  logic             rd_ok;
  logic             wr_ok;

  assign frame     = pte[PTE_W-1 -: PFN_W];
  assign ent_valid = pte[FLAG_VALID];
  assign wr_ok     = pte[FLAG_WR];

  generate
    if (READ_CHECK) begin : g_rd_chk
      assign rd_ok = pte[FLAG_RD];
    end else begin : g_rd_free
      assign rd_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    miss  = !ent_valid;
    prot  = ent_valid && (is_write ? !wr_ok : !rd_ok);
    paddr = (miss || prot) ? '0 : {frame, vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned MEM_AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [MEM_AW-1:0] ptbr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              res_done,
  output logic [PA_W-1:0]   res_paddr,
  output logic              res_miss,
  output logic              res_prot
);
  localparam int unsigned VPN_W = VA_W - OFF_W;

  logic              accept;
  logic              capture;
  logic [VA_W-1:0]   vaddr_q;
  logic              wr_q;
  logic [MEM_AW-1:0] ent_addr_q;
  logic [PA_W-1:0]   chk_paddr;
  logic              chk_miss;
  logic              chk_prot;
  logic [VPN_W-1:0]  vpn;

  assign vpn = req_vaddr[VA_W-1 -: VPN_W];

  pxl_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .mem_rd_ready (mem_rd_ready),
    .rsp_valid    (mem_rsp_valid),
    .req_ready    (req_ready),
    .accept       (accept),
    .rd_valid     (mem_rd_valid),
    .capture      (capture),
    .done         (res_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr_q    <= '0;
      wr_q       <= 1'b0;
      ent_addr_q <= '0;
    end else if (accept) begin
      vaddr_q    <= req_vaddr;
      wr_q       <= req_write;
      ent_addr_q <= ptbr + MEM_AW'(vpn);
    end
  end

  assign mem_rd_addr = ent_addr_q;

  pxl_check #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFF_W (OFF_W),
    .PTE_W (PTE_W)
  ) u_check (
    .pte      (mem_rsp_data),
    .vaddr    (vaddr_q),
    .is_write (wr_q),
    .paddr    (chk_paddr),
    .miss     (chk_miss),
    .prot     (chk_prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_paddr <= '0;
      res_miss  <= 1'b0;
      res_prot  <= 1'b0;
    end else if (capture) begin
      res_paddr <= chk_paddr;
      res_miss  <= chk_miss;
      res_prot  <= chk_prot;
    end
  end

  // R2
  rd_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(res_paddr) && $stable(res_miss) && $stable(res_prot));
  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |-> !(res_miss && res_prot));
  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && (req_ready || mem_rd_valid) |=> !res_done);
endmodule

// File: tb/page_xlate_tb.sv
`timescale 1ns/1ps
module page_xlate_tb;
  typedef struct packed {
    logic [31:0] vaddr;
    logic        wr;
    logic [31:0] pte;
    logic [31:0] base;
    logic [3:0]  rdly;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_0C05, 1'b0, 32'h000A_9403, 32'h0000_1000, 4'd0, 4'd0},
    '{32'hFFFF_FFFF, 1'b1, 32'hFFFF_FC07, 32'h0000_0000, 4'd2, 4'd5},
    '{32'h1234_5678, 1'b0, 32'h0000_0406, 32'h8000_0000, 4'd1, 4'd3},
    '{32'h0000_0400, 1'b1, 32'h0000_0800, 32'h0000_0040, 4'd0, 4'd1},
    '{32'h0040_03FF, 1'b1, 32'h0003_0003, 32'h0000_0020, 4'd3, 4'd0},
    '{32'h0000_0000, 1'b0, 32'h0003_0005, 32'hFFFF_FFF0, 4'd0, 4'd7},
    '{32'h0000_2ABC, 1'b1, 32'h0000_1405, 32'h0000_0100, 4'd1, 4'd2},
    '{32'h7FFF_FC00, 1'b0, 32'h0000_0003, 32'h0000_0000, 4'd0, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] ptbr = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_done;
  logic [31:0] res_paddr;
  logic        res_miss;
  logic        res_prot;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  page_xlate u_dut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_vaddr (req_vaddr), .req_write (req_write), .ptbr (ptbr),
    .mem_rd_valid (mem_rd_valid), .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr (mem_rd_addr), .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data), .res_done (res_done),
    .res_paddr (res_paddr), .res_miss (res_miss), .res_prot (res_prot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] ep;
    logic        em;
    logic        epr;
    string       tag;
    em  = !v.pte[0];
    epr = !em && (v.wr ? !v.pte[2] : !v.pte[1]);
    ep  = (em || epr) ? 32'h0 : {v.pte[31:10], v.vaddr[9:0]};
    tag = em ? "R4 R6" : (epr ? "R4 R7" : "R4 R5");
    @(negedge clk);
    chk("R3 ready idle", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = v.vaddr; req_write = v.wr; ptbr = v.base;
    @(negedge clk);
    req_valid = 1'b0; ptbr = ~v.base; req_vaddr = ~v.vaddr; req_write = ~v.wr;
    chk("R2 entry addr", mem_rd_addr, v.base + {10'b0, v.vaddr[31:10]});
    chk("R3 busy", {31'b0, req_ready}, 32'd0);
    chk("R3 rd valid", {31'b0, mem_rd_valid}, 32'd1);
    for (int i = 0; i < int'(v.rdly); i++) begin
      @(negedge clk);
      chk("R10 rd held", {31'b0, mem_rd_valid}, 32'd1);
      chk("R2 addr held", mem_rd_addr, v.base + {10'b0, v.vaddr[31:10]});
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk("R3 rd dropped", {31'b0, mem_rd_valid}, 32'd0);
    for (int i = 0; i < int'(v.lat); i++) begin
      @(negedge clk);
      chk("R10 no early done", {31'b0, res_done}, 32'd0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = v.pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = ~v.pte;
    chk("R8 done", {31'b0, res_done}, 32'd1);
    chk(tag, res_paddr, ep);
    chk({tag, " miss"}, {31'b0, res_miss}, {31'b0, em});
    chk({tag, " prot"}, {31'b0, res_prot}, {31'b0, epr});
    @(negedge clk);
    chk("R8 done drop", {31'b0, res_done}, 32'd0);
    chk("R8 held", res_paddr, ep);
    chk("R3 ready again", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {27'b0, req_ready, mem_rd_valid, res_done, res_miss, res_prot}, 32'h10);
    chk(tag, res_paddr, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 reset");

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R9: stray response while idle
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FC07;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle no done", {31'b0, res_done}, 32'd0);
    chk("R9 idle paddr", res_paddr, 32'h0);
    chk("R9 idle ready", {31'b0, req_ready}, 32'd1);

    // R9: stray response during fetch phase
    req_valid = 1'b1; req_vaddr = 32'h0000_0C05; req_write = 1'b0; ptbr = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FC07;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R9 fetch no done", {31'b0, res_done}, 32'd0);
    chk("R9 fetch rd held", {31'b0, mem_rd_valid}, 32'd1);
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_0803;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R9 R5 real rsp", res_paddr, 32'h0000_0805);
    chk("R9 done", {31'b0, res_done}, 32'd1);

    // R1: reset in the middle of a transaction
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_1400; ptbr = 32'h10;
    @(negedge clk);
    req_valid = 1'b0; mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R1 mid reset");
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_0C03;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R1 R9 after reset", {31'b0, res_done}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule